// File: doc/BRIEF.md
# Channel Thermal Protection Sequencer

This block gates the drive of a bank of output channels using digital temperature readings. Every channel has its own junction temperature code, and one case temperature code is shared by all channels. When a channel's junction runs too hot, that channel is switched off. It switches back on by itself once the junction has cooled past a lower reset point, so a steady overload makes the channel cycle off and on.

If the case gets too hot while a channel is already switched off, that channel is held off longer. In that situation it restarts only after both its junction and the case are below their reset points. Channels that are not overheating keep following their commands. A single active-low fault flag is the OR of every channel's junction overtemperature condition. It is not latched.

Temperatures are whole-degree unsigned codes. They are registered once, and all threshold comparisons are made on the registered samples. The integration logic supplies the per-channel on/off commands. The block passes each command through unless the thermal state of that channel forbids it.

Top module: `thermal_guard`

## Requirements
- R1: After reset every channel is in the running state, drive_out equals cmd_on, and fault_n is 1 while all temperatures are below their shutdown points.
- R2: A channel switches off when its sampled junction code is strictly greater than J_SHUT (default 170). A code equal to J_SHUT keeps it running. drive_out changes on the second rising edge after the temperature input changes.
- R3: A channel switched off by its junction only restarts when its sampled junction code is strictly below J_RESET (default 150). A code equal to J_RESET keeps it off.
- R4: A junction code between J_RESET and J_SHUT, inclusive of both, leaves a channel in whichever state it already has (hysteresis).
- R5: If the sampled case code is at or above C_SHUT (default 130) while a channel is off or tripping, that channel enters a locked state. It leaves that state only when its junction is below J_RESET and the case is strictly below C_RESET (default 110). A case code equal to C_RESET keeps it locked.
- R6: A case overheat alone does not switch off a channel whose junction is not over J_SHUT.
- R7: Each channel's state depends only on its own junction code and the shared case code. Other channels keep following their commands while one channel is off.
- R8: fault_n is 0 exactly when at least one sampled junction code exceeds J_SHUT, one rising edge after the input changes. It is not latched: a locked channel with a cooled junction does not hold it low.
- R9: drive_out[i] equals cmd_on[i] AND NOT (channel i off or locked), with no register on the command path.
- R10: Under a persistent overload that swings across both junction points, the channel turns off and on repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | NUM_CH | Requested on/off state per channel |
| junc_temp | input | NUM_CH*TEMP_W | Junction temperature codes; channel i occupies bits [i*TEMP_W +: TEMP_W] |
| case_temp | input | TEMP_W | Shared case temperature code |
| drive_out | output | NUM_CH | Gated channel drive |
| fault_n | output | 1 | Active-low OR of junction overtemperature conditions |

## Verification
The bench builds the block with eight channels, 8-bit codes, registered samples and the default thresholds 170/150 for the junction and 130/110 for the case. With these values the exact boundary codes can be driven directly, as can values just above and just below each of them. The locked state can be entered and left while neighbouring channels sit inside the hysteresis band. Random junction codes spread across 120 to 200 and case codes across 90 to 150 make every state transition occur on many channels at once.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
   typedef enum logic [1:0] {
      TG_RUN  = 2'd0,
      TG_JOFF = 2'd1,
      TG_LOCK = 2'd2
   } tg_state_e;
endpackage

// File: rtl/tg_sampler.sv
module tg_sampler #(
   parameter int NUM_CH      = 8,
   parameter int TEMP_W      = 8,
   parameter int J_SHUT      = 170,
   parameter int J_RESET     = 150,
   parameter int C_SHUT      = 130,
   parameter int C_RESET     = 110,
   parameter bit REG_SAMPLES = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*TEMP_W-1:0] junc_temp,
   input  logic [TEMP_W-1:0]        case_temp,
   output logic [NUM_CH-1:0]        j_hot,
   output logic [NUM_CH-1:0]        j_cool,
   output logic                     c_hot,
   output logic                     c_cool
);
   localparam int VEC_W = NUM_CH * TEMP_W;
   localparam logic [TEMP_W-1:0] JS = TEMP_W'(J_SHUT);
   localparam logic [TEMP_W-1:0] JR = TEMP_W'(J_RESET);
   localparam logic [TEMP_W-1:0] CS = TEMP_W'(C_SHUT);
   localparam logic [TEMP_W-1:0] CR = TEMP_W'(C_RESET);

   logic [VEC_W-1:0]  junc_q;
   logic [TEMP_W-1:0] case_q;

   if (REG_SAMPLES) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            junc_q <= '0;
            case_q <= '0;
         end else begin
            junc_q <= junc_temp;
            case_q <= case_temp;
         end
      end
   end else begin : g_pass
      assign junc_q = junc_temp;
      assign case_q = case_temp;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
      assign j_hot[i]  = junc_q[i*TEMP_W +: TEMP_W] > JS;
      assign j_cool[i] = junc_q[i*TEMP_W +: TEMP_W] < JR;
   end

   assign c_hot  = case_q >= CS;
   assign c_cool = case_q < CR;
endmodule

// File: rtl/tg_channel_fsm.sv
module tg_channel_fsm
   import thermal_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic j_hot,
   input  logic j_cool,
   input  logic c_hot,
   input  logic c_cool,
   output logic therm_off
);
   tg_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TG_RUN:  if (j_hot) state_d = c_hot ? TG_LOCK : TG_JOFF;
         TG_JOFF: begin
            if (c_hot)       state_d = TG_LOCK;
            else if (j_cool) state_d = TG_RUN;
         end
         TG_LOCK: if (j_cool && c_cool) state_d = TG_RUN;
         default: state_d = TG_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TG_RUN;
      else        state_q <= state_d;
   end

   assign therm_off = (state_q != TG_RUN);

   // R2: an overheated running channel is off on the next edge
   p_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TG_RUN && j_hot) |=> therm_off);
   // R4: inside the band with a cool case the off state holds
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TG_JOFF && !j_cool && !c_hot) |=> (state_q == TG_JOFF));
   // R5: locked channel stays off until both points are cleared
   p_lock_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TG_LOCK && !(j_cool && c_cool)) |=> (state_q == TG_LOCK));
   // R6: case heat alone never stops a running channel
   p_no_case_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TG_RUN && !j_hot) |=> !therm_off);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
   parameter int NUM_CH      = 8,
   parameter int TEMP_W      = 8,
   parameter int J_SHUT      = 170,
   parameter int J_RESET     = 150,
   parameter int C_SHUT      = 130,
   parameter int C_RESET     = 110,
   parameter bit REG_SAMPLES = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        cmd_on,
   input  logic [NUM_CH*TEMP_W-1:0] junc_temp,
   input  logic [TEMP_W-1:0]        case_temp,
   output logic [NUM_CH-1:0]        drive_out,
   output logic                     fault_n
);
   localparam int CODE_MAX = (1 << TEMP_W) - 1;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("thermal_guard: NUM_CH must be at least 1");
   end
   if (J_RESET >= J_SHUT) begin : g_bad_j
      $error("thermal_guard: junction reset point must lie below shutdown point");
   end
   if (C_RESET >= C_SHUT) begin : g_bad_c
      $error("thermal_guard: case reset point must lie below shutdown point");
   end
   if (J_SHUT >= CODE_MAX || C_SHUT > CODE_MAX) begin : g_bad_w
      $error("thermal_guard: thresholds do not fit TEMP_W");
   end

   logic [NUM_CH-1:0] j_hot, j_cool, therm_off;
   logic              c_hot, c_cool;

   tg_sampler #(
      .NUM_CH(NUM_CH), .TEMP_W(TEMP_W),
      .J_SHUT(J_SHUT), .J_RESET(J_RESET),
      .C_SHUT(C_SHUT), .C_RESET(C_RESET),
      .REG_SAMPLES(REG_SAMPLES)
   ) i_sampler (
      .clk(clk), .rst_n(rst_n),
      .junc_temp(junc_temp), .case_temp(case_temp),
      .j_hot(j_hot), .j_cool(j_cool),
      .c_hot(c_hot), .c_cool(c_cool)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tg_channel_fsm i_fsm (
         .clk(clk), .rst_n(rst_n),
         .j_hot(j_hot[i]), .j_cool(j_cool[i]),
         .c_hot(c_hot), .c_cool(c_cool),
         .therm_off(therm_off[i])
      );
   end

   assign drive_out = cmd_on & ~therm_off;
   assign fault_n   = ~(|j_hot);
endmodule

// File: tb/test_thermal_guard.sv
module test_thermal_guard;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int W   = 8;
   localparam int JS = 170, JR = 150, CS = 130, CR = 110;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   cmd = '0;
   logic [NCH*W-1:0] jt = '0;
   logic [W-1:0]     ct = '0;
   logic [NCH-1:0]   drive_out;
   logic             fault_n;

   int n_checks = 0;
   int n_fail = 0;
   int mst[NCH];
   int msj[NCH];
   int msc;

   always #(CLK_PERIOD/2) clk = ~clk;

   thermal_guard #(
      .NUM_CH(NCH), .TEMP_W(W),
      .J_SHUT(JS), .J_RESET(JR), .C_SHUT(CS), .C_RESET(CR),
      .REG_SAMPLES(1'b1)
   ) i_thermal_guard (
      .clk(clk), .rst_n(rst_n), .cmd_on(cmd),
      .junc_temp(jt), .case_temp(ct),
      .drive_out(drive_out), .fault_n(fault_n)
   );

   // state codes: 0 running, 1 off by junction, 2 locked by case
   function automatic int next_st(int st, int j, int c);
      case (st)
         0: return (j > JS) ? ((c >= CS) ? 2 : 1) : 0;
         1: return (c >= CS) ? 2 : ((j < JR) ? 0 : 1);
         default: return (j < JR && c < CR) ? 0 : 2;
      endcase
   endfunction

   function automatic logic [NCH-1:0] exp_drive();
      logic [NCH-1:0] d;
      for (int i = 0; i < NCH; i++) d[i] = cmd[i] && (mst[i] == 0);
      return d;
   endfunction

   function automatic logic exp_fault_n();
      for (int i = 0; i < NCH; i++) if (msj[i] > JS) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input string tag);
      logic [NCH-1:0] ed;
      logic ef;
      ed = exp_drive();
      ef = exp_fault_n();
      n_checks++;
      if (drive_out !== ed) begin
         n_fail++;
         $display("FAIL %s drive_out actual %h expected %h", tag, drive_out, ed);
      end
      n_checks++;
      if (fault_n !== ef) begin
         n_fail++;
         $display("FAIL %s fault_n actual %b expected %b", tag, fault_n, ef);
      end
   endtask

   task automatic set_j(input int ch, input int v);
      jt[ch*W +: W] = W'(v);
   endtask

   task automatic cycle(input string tag);
      @(posedge clk);
      for (int i = 0; i < NCH; i++) mst[i] = next_st(mst[i], msj[i], msc);
      for (int i = 0; i < NCH; i++) msj[i] = int'(jt[i*W +: W]);
      msc = int'(ct);
      @(negedge clk);
      check(tag);
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) cycle(tag);
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) begin
         mst[i] = 0;
         msj[i] = 0;
      end
      msc = 0;
      void'($urandom(32'd4711));
      cmd = 8'hA5;
      for (int i = 0; i < NCH; i++) set_j(i, 25);
      ct = 8'd25;
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      run(3, "R1");

      // R9: command path is combinational
      cmd = 8'h3C;
      #1 check("R9");
      cmd = 8'hFF;
      #1 check("R9");
      run(2, "R9");

      // R2: equal to the shutdown point keeps running, one above trips
      set_j(0, 170); run(3, "R2");
      set_j(0, 171); run(3, "R2");
      // R4: band keeps it off; R3: exact reset point still off, below restarts
      set_j(0, 160); run(3, "R4");
      set_j(0, 150); run(3, "R3");
      set_j(0, 149); run(3, "R3");
      // R4: band keeps a running channel on
      set_j(0, 165); run(3, "R4");
      set_j(0, 25);  run(2, "R4");

      // R6: hot case with cool junctions changes nothing
      ct = 8'd200; run(4, "R6");
      ct = 8'd25;  run(2, "R6");

      // R5: trip, case overheat, lock, cool junction, exact case reset, release
      set_j(1, 180); run(3, "R5");
      ct = 8'd130;   run(3, "R5");
      set_j(1, 100); run(3, "R5");
      ct = 8'd110;   run(3, "R8");
      ct = 8'd109;   run(3, "R5");
      // R5: trip while case already hot goes straight to lock
      ct = 8'd140; set_j(1, 190); run(2, "R5");
      set_j(1, 100); ct = 8'd25; run(3, "R5");

      // R7: one channel hot, neighbours inside the band keep running
      for (int i = 0; i < NCH; i++) set_j(i, 160);
      set_j(2, 200); run(4, "R7");
      for (int i = 0; i < NCH; i++) set_j(i, 25);
      run(3, "R7");

      // R8: fault follows sample and releases without latching
      set_j(4, 171); run(1, "R8");
      set_j(4, 100); run(3, "R8");

      // R10: persistent overload cycles the channel
      for (int k = 0; k < 5; k++) begin
         set_j(5, 175); run(2, "R10");
         set_j(5, 140); run(2, "R10");
      end
      set_j(5, 25); run(2, "R10");

      // random mix across all channels
      for (int k = 0; k < 3000; k++) begin
         cmd = NCH'($urandom);
         for (int i = 0; i < NCH; i++) set_j(i, 120 + int'($urandom_range(80)));
         ct = W'(90 + int'($urandom_range(60)));
         cycle("R7");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule